// File: doc/BRIEF.md
# I2C SCL Low/High Timing Generator

This block produces the SCL clock of an I2C controller from a functional clock. A programmable prescaler divides the functional clock into an internal timing tick. Two programmable counts then set how many ticks SCL is held low and how many ticks it is left high. Each phase length is the programmed count plus a fixed offset that the hardware adds: 7 for the low phase and 5 for the high phase. The SCL period therefore depends only on the sum of the two counts, and the way that sum is split between them sets the duty cycle. For example, at a 9.6 MHz tick, counts of 9/3 and 7/5 both give a 24-tick (400 kHz) period. The 9/3 split gives 16 ticks low and 8 ticks high.

SCL is driven as an open-drain line. The block only ever requests a low drive, and it senses the real line level. The high-phase count advances only on ticks where the line is sensed high. A target that stretches the clock, or a slow rising edge, therefore makes the high phase longer instead of eating into it. Two one-cycle strobes tell the data-path sequencer when to act: one at the middle of the low phase, where SDA may change, and one when the high phase begins, where SDA is sampled.

The low count, high count and prescaler are captured at the start of every low phase. Software may rewrite them at any time without producing a shortened phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted or the enable is low, `scl_drive_low_o`, `mid_low_stb_o` and `high_start_stb_o` are all 0.
- R2: Every low phase lasts (SCLL + 7) internal ticks.
- R3: Without stretching, every high phase lasts (SCLH + 5) internal ticks.
- R4: One internal tick equals (PSC + 1) functional clock cycles, so a phase of N ticks spans N*(PSC+1) cycles.
- R5: In the cycle after the enable is first sampled high, `scl_drive_low_o` is 1, and the low phase starts with full length.
- R6: The high-phase count advances only on ticks where `scl_sense_i` is 1. If the line is held low for S cycles after release (with PSC = 0), the high phase lasts S + SCLH + 5 cycles.
- R7: SCLL, SCLH and PSC are captured when a low phase starts. A change made during a low phase does not affect that low phase or the high phase after it, and applies from the next low phase onward.
- R8: `mid_low_stb_o` pulses for one cycle, on the tick that follows floor(L/2) elapsed ticks of a low phase of L ticks. This is cycle offset floor(L/2)*(PSC+1)+PSC from the first low cycle.
- R9: `high_start_stb_o` pulses for one cycle, in the first cycle of a high phase in which `scl_sense_i` is 1.
- R10: Dropping the enable releases SCL in the next cycle. Re-enabling starts a fresh, full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Generator enable |
| psc_i | input | PSC_W | Prescaler value; tick = clk/(PSC+1) |
| scll_i | input | CNT_W | Low-phase count (offset 7 added) |
| sclh_i | input | CNT_W | High-phase count (offset 5 added) |
| scl_sense_i | input | 1 | Sensed SCL line level |
| scl_drive_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| mid_low_stb_o | output | 1 | Midpoint-of-low strobe |
| high_start_stb_o | output | 1 | Start-of-high strobe |

## Verification
The assertions assume that `scl_sense_i` is never high while the block drives SCL low, which matches the wired-AND line of a real bus. The bench models the line as the inverse of the drive, optionally held low for a chosen number of cycles after release. The assertions also assume that the configuration inputs are plain register values that may change in any cycle. The bench therefore changes them in the middle of a phase, rather than only while the block is idle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic             wrap;

  assign wrap   = (pcnt_q >= psc_i);
  assign tick_o = run_i && wrap;

  always_comb begin
    if (!run_i)    pcnt_d = '0;
    else if (wrap) pcnt_d = '0;
    else           pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R4
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pcnt_q <= psc_i));
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PSC_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] scll_i,
  input  logic [CNT_W-1:0] sclh_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             scl_sense_i,
  output logic             run_o,
  output logic [PSC_W-1:0] psc_lat_o,
  output logic             drive_low_o,
  output logic             mid_stb_o,
  output logic             hstart_stb_o
);
  localparam int LEN_W = CNT_W + 1;
  localparam logic [LEN_W-1:0] LOW_ADD  = LEN_W'(LOW_OFS);
  localparam logic [LEN_W-1:0] HIGH_ADD = LEN_W'(HIGH_OFS);
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

  scl_phase_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] low_len_q;
  logic [CNT_W-1:0] sclh_lat_q;
  logic [PSC_W-1:0] psc_lat_q;
  logic             hi_seen_q, hi_seen_d;
  logic             start;
  logic [LEN_W-1:0] mid_point;

  // next-state process
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    hi_seen_d = hi_seen_q;
    start     = 1'b0;
    if (!en_i) begin
      state_d   = PH_IDLE;
      cnt_d     = '0;
      hi_seen_d = 1'b0;
    end else begin
      unique case (state_q)
        PH_IDLE: start = 1'b1;
        PH_LOW: begin
          if (tick_i) begin
            if (cnt_q == ONE) begin
              state_d   = PH_HIGH;
              cnt_d     = {1'b0, sclh_lat_q} + HIGH_ADD;
              hi_seen_d = 1'b0;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        PH_HIGH: begin
          if (scl_sense_i) hi_seen_d = 1'b1;
          if (tick_i && scl_sense_i) begin
            if (cnt_q == ONE) start = 1'b1;
            else              cnt_d = cnt_q - ONE;
          end
        end
        default: state_d = PH_IDLE;
      endcase
      if (start) begin
        state_d = PH_LOW;
        cnt_d   = {1'b0, scll_i} + LOW_ADD;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      hi_seen_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      hi_seen_q <= hi_seen_d;
    end
  end

  // configuration shadow, loaded only when a low phase starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_q  <= '0;
      sclh_lat_q <= '0;
      psc_lat_q  <= '0;
    end else if (start) begin
      low_len_q  <= {1'b0, scll_i} + LOW_ADD;
      sclh_lat_q <= sclh_i;
      psc_lat_q  <= psc_i;
    end
  end

  assign mid_point    = low_len_q - (low_len_q >> 1);
  assign run_o        = (state_q != PH_IDLE);
  assign psc_lat_o    = psc_lat_q;
  assign drive_low_o  = (state_q == PH_LOW);
  assign mid_stb_o    = (state_q == PH_LOW) && tick_i && (cnt_q == mid_point);
  assign hstart_stb_o = (state_q == PH_HIGH) && scl_sense_i && !hi_seen_q;

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HIGH && en_i && !scl_sense_i) |=> (cnt_q == $past(cnt_q)));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LOW && en_i) |=>
      (state_q != PH_LOW || (low_len_q == $past(low_len_q) &&
                             psc_lat_q == $past(psc_lat_q) &&
                             sclh_lat_q == $past(sclh_lat_q))));

  // R3
  high_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HIGH) |-> (cnt_q != '0));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W    = 8,
  parameter int PSC_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] scll_i,
  input  logic [CNT_W-1:0] sclh_i,
  input  logic             scl_sense_i,
  output logic             scl_drive_low_o,
  output logic             mid_low_stb_o,
  output logic             high_start_stb_o
);
  logic             rst_n_s;
  logic             run;
  logic             tick;
  logic [PSC_W-1:0] psc_lat;

  scl_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_i  (run),
    .psc_i  (psc_lat),
    .tick_o (tick)
  );

  scl_phase_ctrl #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .en_i         (en_i),
    .tick_i       (tick),
    .scll_i       (scll_i),
    .sclh_i       (sclh_i),
    .psc_i        (psc_i),
    .scl_sense_i  (scl_sense_i),
    .run_o        (run),
    .psc_lat_o    (psc_lat),
    .drive_low_o  (scl_drive_low_o),
    .mid_stb_o    (mid_low_stb_o),
    .hstart_stb_o (high_start_stb_o)
  );

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en_i |=> !scl_drive_low_o);

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en_i |=> !(mid_low_stb_o || high_start_stb_o));
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] psc = '0, scll = '0, sclh = '0;
  logic       scl_line;
  logic       drv, mstb, hstb;
  int         stretch_len = 0;
  logic [15:0] rel_cnt;
  int         checks = 0, fails = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .psc_i(psc), .scll_i(scll),
    .sclh_i(sclh), .scl_sense_i(scl_line), .scl_drive_low_o(drv),
    .mid_low_stb_o(mstb), .high_start_stb_o(hstb)
  );

  // wired line: low while driven, optionally held low after release
  always_ff @(posedge clk) begin
    if (drv) rel_cnt <= '0;
    else if (rel_cnt != 16'hFFFF) rel_cnt <= rel_cnt + 1'b1;
  end
  assign scl_line = !drv && (int'(rel_cnt) >= stretch_len);

  // psc, scll, sclh, low cycles, high cycles, mid offset
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{0,   9,   3,  16,   8,   8},
    '{0,   7,   5,  14,  10,   7},
    '{1,   9,   3,  32,  16,  17},
    '{2,   0,   0,  21,  15,  11},
    '{0, 255, 255, 262, 260, 131},
    '{3,  20,   1, 108,  24,  55}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // entered at the negedge of a first low cycle; leaves at the next one
  task automatic meas(output int lo, output int hi, output int moff, output int hoff);
    lo = 0; hi = 0; moff = -1; hoff = -1;
    while (drv) begin
      if (mstb && moff < 0) moff = lo;
      lo++;
      @(negedge clk);
    end
    while (!drv) begin
      if (hstb && hoff < 0) hoff = hi;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic start_gen(input int p, input int l, input int h);
    en = 1'b0;
    psc = 8'(p); scll = 8'(l); sclh = 8'(h);
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lo, hi, mo, ho;
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 reset drive", int'(drv), 0);
    chk("R1 reset strobes", int'(mstb | hstb), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 disabled drive", int'(drv), 0);

    // table walk: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      start_gen(VEC[v][0], VEC[v][1], VEC[v][2]);
      chk("R5 low after enable", int'(drv), 1);
      for (int k = 0; k < 2; k++) begin
        meas(lo, hi, mo, ho);
        chk("R2 R4 low length", lo, VEC[v][3]);
        chk("R3 R4 high length", hi, VEC[v][4]);
        chk("R8 mid strobe offset", mo, VEC[v][5]);
        chk("R9 high strobe offset", ho, 0);
      end
    end

    // R7: config change during a low phase
    start_gen(0, 9, 3);
    scll = 8'd0; sclh = 8'd0; psc = 8'd1;
    meas(lo, hi, mo, ho);
    chk("R7 current low kept", lo, 16);
    chk("R7 following high kept", hi, 8);
    meas(lo, hi, mo, ho);
    chk("R7 new low applied", lo, 14);
    chk("R7 new high applied", hi, 10);

    // R6: stretched high phase
    start_gen(0, 9, 3);
    stretch_len = 4;
    meas(lo, hi, mo, ho);
    chk("R6 stretched high", hi, 12);
    chk("R9 strobe after stretch", ho, 4);
    stretch_len = 0;

    // R10: disable mid-low and restart
    start_gen(0, 9, 3);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R10 released", int'(drv), 0);
    mo = 0;
    for (int i = 0; i < 10; i++) begin
      if (drv || mstb || hstb) mo++;
      @(negedge clk);
    end
    chk("R1 R10 quiet while disabled", mo, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R10 restart low", int'(drv), 1);
    meas(lo, hi, mo, ho);
    chk("R10 full low after restart", lo, 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule